// File: doc/BRIEF.md
# External Oscillator Clock Failure Supervisor

This block supervises an external high-speed oscillator from the always-running reference clock domain. Software turns supervision on with an enable bit. The detector arms only when three conditions hold: supervision is enabled, the oscillator is requested on, and the oscillator reports ready after its startup delay. It then watches a toggle signal driven from the oscillator domain. If no toggle change is seen for a parameterised number of reference cycles, the block declares a clock failure.

On a failure the block does four things in the same cycle:
- It forces the oscillator off.
- It sends a one-cycle break pulse to a timer.
- It forces the system clock selection to the internal RC source.
- It sets a non-maskable interrupt pending bit. The bit stays set until software clears it.

After a failure the detector stays disarmed until software drops its oscillator request, raises it again, and ready is reported.

Top module: `clk_fail_supervisor`

## Requirements
- R1: After a synchronous reset all four outputs are low (`osc_force_off`, `tmr_break`, `nmi_pending`, `sel_fallback`).
- R2: The detector arms only while `mon_enable`, `osc_on` and `osc_ready` are all high and `osc_force_off` is low. With any of these conditions missing, no failure is ever reported, however long the oscillator is silent.
- R3: Edges are seen through `SYNC_STAGES` flops. A change of `osc_toggle` counts as one edge. Once armed, a failure is declared when `TIMEOUT` consecutive reference cycles pass with no detected edge. With default parameters, if the inputs that arm the detector are set before clock edge k and no edge is pending, the failure outputs are visible after edge k+`TIMEOUT`.
- R4: Every detected edge restarts the silence window, so an oscillator that toggles at least once every `TIMEOUT` cycles never trips.
- R5: A failure sets `osc_force_off`. It stays high while `osc_on` is high and clears in the cycle after `osc_on` is seen low.
- R6: `tmr_break` is high for exactly one cycle per failure.
- R7: A failure sets `nmi_pending`. It stays set until `irq_clear` is seen high. If a failure and a clear happen in the same cycle, the bit stays set.
- R8: A failure sets `sel_fallback`. It is released in the cycle after the detector is next found armed.
- R9: If any arming condition drops, the detector disarms and discards the partial silence count. A later re-arm starts a full window.
- R10: After a failure, the detector does not re-arm while `osc_on` stays high, even with `osc_ready` high. It re-arms only after `osc_on` has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_enable | input | 1 | Software enable for supervision |
| osc_on | input | 1 | Software request to run the oscillator |
| osc_ready | input | 1 | Oscillator stable after startup delay |
| osc_toggle | input | 1 | Bit toggled in the oscillator domain on each oscillator edge |
| irq_clear | input | 1 | Strobe that clears the pending interrupt |
| osc_force_off | output | 1 | Forced oscillator disable after a failure |
| tmr_break | output | 1 | One-cycle break pulse to a timer |
| nmi_pending | output | 1 | Sticky non-maskable interrupt pending flag |
| sel_fallback | output | 1 | Forces system clock selection to the internal RC source |

## Verification
The embedded assertions check several properties on every cycle:
- the break pulse never lasts two cycles;
- a failure raises the disable, fallback and pending outputs together;
- the pending bit and the forced disable hold until their release conditions;
- the silence counter never passes its limit;
- no failure is declared while disarmed.

Other behaviours appear only in the bench's scenarios. These are:
- the exact trip latency after arming;
- the immunity to an oscillator toggling inside the window;
- the restart of the window after ready drops;
- the lockout until the oscillator request is cycled;
- a clear that lands in the very cycle of a failure.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  // Outputs produced by the event latch, grouped for a single port
  typedef struct packed {
    logic force_off;
    logic brk;
    logic pending;
    logic fallback;
  } cfs_evt_t;

  localparam cfs_evt_t CFS_EVT_IDLE = '{force_off: 1'b0, brk: 1'b0,
                                        pending: 1'b0, fallback: 1'b0};

endpackage

// File: rtl/cfs_sync_chain.sv
module cfs_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic edge_seen
);

  logic [STAGES-1:0] stage_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= stage_q[STAGES-1];
  end

  // Any change of the synchronised toggle marks one oscillator edge
  assign edge_seen = stage_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/cfs_activity_timer.sv
module cfs_activity_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic edge_seen,
  output logic fail
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST_QUIET = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] CNT_MAX    = CW'(TIMEOUT);

  logic [CW-1:0] quiet_q;

  assign fail = armed && !edge_seen && (quiet_q == LAST_QUIET);

  always_ff @(posedge clk) begin
    if (rst || !armed || edge_seen) quiet_q <= '0;
    else if (quiet_q != CNT_MAX)    quiet_q <= quiet_q + 1'b1;
  end

  AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (rst)
    quiet_q <= CNT_MAX);  // R3

  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !armed |=> quiet_q == '0);  // R9

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> quiet_q == '0);  // R4

endmodule

// File: rtl/cfs_event_latch.sv
module cfs_event_latch
  import cfs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fail,
  input  logic     armed,
  input  logic     osc_on,
  input  logic     irq_clear,
  output cfs_evt_t evt
);

  cfs_evt_t evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= CFS_EVT_IDLE;
    end else begin
      evt_q.brk <= fail;
      // Forced disable holds until software withdraws its oscillator request
      if (fail)         evt_q.force_off <= 1'b1;
      else if (!osc_on) evt_q.force_off <= 1'b0;
      // Set has priority over a clear in the same cycle
      if (fail)           evt_q.pending <= 1'b1;
      else if (irq_clear) evt_q.pending <= 1'b0;
      // Fallback selection released once the detector is armed again
      if (fail)       evt_q.fallback <= 1'b1;
      else if (armed) evt_q.fallback <= 1'b0;
    end
  end

  assign evt = evt_q;

  AST_BREAK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    evt_q.brk |=> !evt_q.brk);  // R6

  AST_FAIL_ACTIONS: assert property (@(posedge clk) disable iff (rst)
    evt_q.brk |-> (evt_q.force_off && evt_q.pending && evt_q.fallback));  // R5

  AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (rst)
    (evt_q.pending && !irq_clear) |=> evt_q.pending);  // R7

  AST_KILL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (evt_q.force_off && osc_on) |=> evt_q.force_off);  // R5

endmodule

// File: rtl/clk_fail_supervisor.sv
module clk_fail_supervisor
  import cfs_pkg::*;
#(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_enable,
  input  logic osc_on,
  input  logic osc_ready,
  input  logic osc_toggle,
  input  logic irq_clear,
  output logic osc_force_off,
  output logic tmr_break,
  output logic nmi_pending,
  output logic sel_fallback
);

  logic     edge_seen;
  logic     fail;
  logic     armed_q;
  logic     arm_cond;
  cfs_evt_t evt;

  cfs_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .async_in  (osc_toggle),
    .edge_seen (edge_seen)
  );

  cfs_activity_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .armed     (armed_q),
    .edge_seen (edge_seen),
    .fail      (fail)
  );

  // Armed only with supervision on, oscillator requested and ready, not tripped
  assign arm_cond = mon_enable && osc_on && osc_ready && !evt.force_off && !fail;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= arm_cond;
  end

  cfs_event_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .fail      (fail),
    .armed     (armed_q),
    .osc_on    (osc_on),
    .irq_clear (irq_clear),
    .evt       (evt)
  );

  assign osc_force_off = evt.force_off;
  assign tmr_break     = evt.brk;
  assign nmi_pending   = evt.pending;
  assign sel_fallback  = evt.fallback;

  AST_NO_FAIL_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !tmr_break);  // R2

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    osc_force_off |=> !armed_q);  // R10

endmodule

// File: tb/tb_clk_fail_supervisor.sv
module tb_clk_fail_supervisor;

  localparam int T    = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mon_enable = 0, osc_on = 0, osc_ready = 0, osc_toggle = 0, irq_clear = 0;
  logic osc_force_off, tmr_break, nmi_pending, sel_fallback;

  int checks = 0;
  int fails  = 0;
  int brk_cnt = 0;

  always #2.5 clk = ~clk;

  clk_fail_supervisor #(.TIMEOUT(T), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .mon_enable(mon_enable), .osc_on(osc_on),
    .osc_ready(osc_ready), .osc_toggle(osc_toggle), .irq_clear(irq_clear),
    .osc_force_off(osc_force_off), .tmr_break(tmr_break),
    .nmi_pending(nmi_pending), .sel_fallback(sel_fallback)
  );

  // Behavioural reference
  bit hist[$];
  bit m_last, m_armed, m_kill, m_brk, m_pend, m_fb;
  int m_quiet;

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < SYNC; i++) hist.push_back(1'b0);
    m_last = 0; m_armed = 0; m_kill = 0; m_brk = 0; m_pend = 0; m_fb = 0;
    m_quiet = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      bit oldest, e, f, next_arm;
      oldest   = hist[SYNC-1];
      e        = (oldest != m_last);
      f        = m_armed && !e && (m_quiet == T - 1);
      next_arm = mon_enable && osc_on && osc_ready && !m_kill && !f;
      if (!m_armed || e) m_quiet = 0;
      else if (m_quiet < T) m_quiet++;
      if (f) m_kill = 1; else if (!osc_on) m_kill = 0;
      if (f) m_pend = 1; else if (irq_clear) m_pend = 0;
      if (f) m_fb = 1; else if (m_armed) m_fb = 0;
      m_brk  = f;
      m_last = oldest;
      void'(hist.pop_back());
      hist.push_front(osc_toggle);
      m_armed = next_arm;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 osc_force_off", osc_force_off, m_kill);
      chk("R6 tmr_break",     tmr_break,     m_brk);
      chk("R7 nmi_pending",   nmi_pending,   m_pend);
      chk("R8 sel_fallback",  sel_fallback,  m_fb);
      if (tmr_break) brk_cnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_for(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      if (i % period == 0) osc_toggle = ~osc_toggle;
      @(negedge clk);
    end
  endtask

  task automatic run();
    int base, waited;
    cyc(3);
    chk("R1 force_off reset", osc_force_off, 1'b0);
    chk("R1 break reset",     tmr_break,     1'b0);
    chk("R1 pending reset",   nmi_pending,   1'b0);
    chk("R1 fallback reset",  sel_fallback,  1'b0);
    rst = 0;
    cyc(2);

    // R2: silent oscillator with supervision disabled never trips
    osc_on = 1; osc_ready = 1;
    base = brk_cnt;
    cyc(5 * T);
    chk("R2 no trip while disabled", 1'(brk_cnt != base), 1'b0);

    // R4: toggling inside the window never trips
    mon_enable = 1;
    base = brk_cnt;
    toggle_for(10 * T, T - 3);
    chk("R4 no trip while toggling", 1'(brk_cnt != base), 1'b0);

    // Disarm, let the sync chain settle, then measure latency (R3)
    osc_ready = 0;
    cyc(SYNC + 4);
    osc_ready = 1;
    waited = 0;
    while (!tmr_break && waited < 4 * T) begin
      @(negedge clk);
      waited++;
    end
    chk("R3 trip latency", 1'(waited == T + 1), 1'b1);
    chk("R5 force_off set", osc_force_off, 1'b1);
    chk("R8 fallback set",  sel_fallback,  1'b1);
    cyc(1);
    chk("R6 break is one cycle", tmr_break, 1'b0);

    // R7: sticky until cleared
    cyc(20);
    chk("R7 pending sticky", nmi_pending, 1'b1);
    irq_clear = 1; cyc(1); irq_clear = 0;
    chk("R7 pending cleared", nmi_pending, 1'b0);

    // R10: no re-arm while osc_on stays high
    base = brk_cnt;
    cyc(4 * T);
    chk("R10 locked out", 1'(brk_cnt != base), 1'b0);
    chk("R5 force_off held", osc_force_off, 1'b1);

    // Cycle the request: force_off releases, detector re-arms, fallback drops
    osc_on = 0; cyc(1);
    chk("R5 force_off released", osc_force_off, 1'b0);
    osc_on = 1; cyc(3);
    chk("R8 fallback released on re-arm", sel_fallback, 1'b0);

    // R9: dropping ready mid-window restarts a full window
    cyc(T - 6);
    osc_ready = 0; cyc(2); osc_ready = 1;
    base = brk_cnt;
    cyc(T - 4);
    chk("R9 partial count discarded", 1'(brk_cnt != base), 1'b0);
    cyc(2 * T);
    chk("R9 trips after full window", 1'(brk_cnt == base + 1), 1'b1);

    // R7: clear strobed in the very cycle of a failure; set wins
    irq_clear = 1; cyc(1); irq_clear = 0;
    osc_on = 0; cyc(2);
    osc_on = 1;            // arming inputs set before edge k
    cyc(T);                // now before edge k+T, the failing edge
    irq_clear = 1; cyc(1); irq_clear = 0;
    chk("R7 set beats clear", nmi_pending, 1'b1);
    chk("R6 break on same failure", tmr_break, 1'b1);
    cyc(5);
  endtask

  initial begin
    bit timed_out = 0;
    fork
      run();
      begin cyc(50000); timed_out = 1; end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule